// File: doc/BRIEF.md
# Coin Purse Sale Decider

This block holds the decision logic of a small snack vending machine that takes dimes and quarters. Each coin type drops into a short chain of slots, and each slot has a presence sensor. The slots of a chain fill in a fixed order, so the number of coins of each type can be read from how far the chain is filled. No counter is kept. When the buyer presses the purchase button, the block judges the purse against a fixed price. It then raises one of three outcomes: sell, sell and give change, or refuse the sale.

The price is a build-time parameter, with variants of 35, 45 and 55 cents. The 55-cent variant adds one nickel slot and allows four coins in the purse. The other variants allow three. Slot patterns that break the fill order, and purses with more coins than allowed, are treated as untrustworthy and refused. The outcomes are registered. They reflect the sensors and button as sampled on the previous clock edge, so they stay up only while the button is held. Checking that a coin is genuine and paying out the change amount are left to other logic.

Top module: `coin_vend_decider`

## Requirements
- R1: While `rst` is high, and on the first clock edges after it, `sale_ok`, `give_change` and `sale_refused` are all 0.
- R2: If `buy_request` was 0 at a rising edge, all three outputs are 0 after that edge, whatever the slots hold.
- R3: Dime slots fill from bit 0 upward. A pattern where a dime bit is 1 while a lower dime bit is 0 makes a held request produce `sale_refused`=1 and `sale_ok`=0.
- R4: Quarter slots follow the same order rule as dime slots, from bit 0 upward. A pattern that breaks it is refused.
- R5: With a request held and a valid purse, `sale_ok`=1 when the value (10 cents per filled dime slot, 25 per filled quarter slot, plus the nickel where enabled) is at least `PRICE_CENTS`.
- R6: `give_change`=1 exactly when `sale_ok`=1 and the value is strictly above the price. At an exact price it stays 0.
- R7: With a request held, `sale_refused`=1 when the purse is empty or its value is below the price.
- R8: `sale_refused` is never 1 in the same cycle as `sale_ok` or `give_change`.
- R9: If the filled slots (dimes, quarters, and the nickel where enabled) number more than the coin limit, the purse is refused. The limit is 3, or 4 in the 55-cent variant.
- R10: `nickel_slot` adds 5 cents and one coin only when `PRICE_CENTS` is 55. In the other variants it has no effect on any output.
- R11: Each output reflects the inputs sampled at the previous rising edge: one register stage from inputs to outputs.
- R12: The variants with `PRICE_CENTS` of 35, 45 and 55 each decide against their own price.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dime_slot | input | DIME_SLOTS | Dime slot sensors, bit 0 fills first |
| quarter_slot | input | QUARTER_SLOTS | Quarter slot sensors, bit 0 fills first |
| nickel_slot | input | 1 | Nickel slot sensor, used only in the 55-cent variant |
| buy_request | input | 1 | Purchase button, held by the buyer |
| sale_ok | output | 1 | Registered accept strobe |
| give_change | output | 1 | Registered change strobe |
| sale_refused | output | 1 | Registered reject strobe |

## Verification
The hardest cases to reach are the ones where a purse has enough value and still must be refused. These are out-of-order slot patterns, and over-full purses such as three dimes and two quarters. Both paths also feed the sell decision. The stimulus walks every combination of dime, quarter and nickel sensors, with the button both held and released. It does this on three copies of the block built at 35, 45 and 55 cents, so the order rule, the coin limit and the ignored nickel are all reached next to the exact-price and just-below-price purses.

// File: rtl/coin_vend_pkg.sv
package coin_vend_pkg;
  localparam int NICKEL_CENTS  = 5;
  localparam int DIME_CENTS    = 10;
  localparam int QUARTER_CENTS = 25;
  localparam int NICKEL_PRICE  = 55;

  typedef struct packed {
    logic sell;
    logic change;
    logic refuse;
  } vend_outcome_t;
endpackage

// File: rtl/coin_slot_chain.sv
module coin_slot_chain #(
  parameter int N  = 3,
  parameter int CW = $clog2(N + 1)
) (
  input  logic [N-1:0]  slots,
  output logic [CW-1:0] filled,
  output logic          in_order
);
  logic [N-1:0] link_ok;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_link
      if (g == 0) begin : g_first
        assign link_ok[g] = 1'b1;
      end else begin : g_rest
        assign link_ok[g] = !slots[g] || slots[g-1];
      end
    end
  endgenerate

  assign in_order = &link_ok;

  always_comb begin
    filled = '0;
    for (int i = 0; i < N; i++) begin
      filled = filled + CW'(slots[i]);
    end
  end
endmodule

// File: rtl/coin_purse_value.sv
module coin_purse_value
  import coin_vend_pkg::*;
#(
  parameter int DIME_SLOTS    = 3,
  parameter int QUARTER_SLOTS = 2,
  parameter int NICKEL_EN     = 0,
  parameter int MAX_COINS     = 3,
  parameter int VW            = 7
) (
  input  logic [DIME_SLOTS-1:0]    dime_slot,
  input  logic [QUARTER_SLOTS-1:0] quarter_slot,
  input  logic                     nickel_slot,
  output logic [VW-1:0]            value,
  output logic                     purse_ok
);
  localparam int DCW = $clog2(DIME_SLOTS + 1);
  localparam int QCW = $clog2(QUARTER_SLOTS + 1);
  localparam int CCW = $clog2(DIME_SLOTS + QUARTER_SLOTS + 2);

  logic [DCW-1:0] dimes;
  logic [QCW-1:0] quarters;
  logic           dimes_ordered, quarters_ordered;
  logic           nickel_eff;
  logic [CCW-1:0] coins;

  coin_slot_chain #(.N(DIME_SLOTS), .CW(DCW)) u_dimes (
    .slots(dime_slot), .filled(dimes), .in_order(dimes_ordered)
  );

  coin_slot_chain #(.N(QUARTER_SLOTS), .CW(QCW)) u_quarters (
    .slots(quarter_slot), .filled(quarters), .in_order(quarters_ordered)
  );

  generate
    if (NICKEL_EN != 0) begin : g_nickel
      assign nickel_eff = nickel_slot;
    end else begin : g_no_nickel
      assign nickel_eff = nickel_slot & 1'b0;
    end
  endgenerate

  assign coins = CCW'(dimes) + CCW'(quarters) + CCW'(nickel_eff);

  assign value = VW'(dimes) * VW'(DIME_CENTS)
               + VW'(quarters) * VW'(QUARTER_CENTS)
               + (nickel_eff ? VW'(NICKEL_CENTS) : '0);

  assign purse_ok = dimes_ordered && quarters_ordered && (coins <= CCW'(MAX_COINS));
endmodule

// File: rtl/vend_decide.sv
module vend_decide
  import coin_vend_pkg::*;
#(
  parameter int PRICE_CENTS = 35,
  parameter int VW          = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          request,
  input  logic          purse_ok,
  input  logic [VW-1:0] value,
  output vend_outcome_t outcome
);
  localparam logic [VW-1:0] PRICE_V = VW'(PRICE_CENTS);

  vend_outcome_t next_outcome;

  always_comb begin
    next_outcome = '0;
    if (request) begin
      if (purse_ok && (value >= PRICE_V)) begin
        next_outcome.sell   = 1'b1;
        next_outcome.change = (value > PRICE_V);
      end else begin
        next_outcome.refuse = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) outcome <= '0;
    else     outcome <= next_outcome;
  end

  assert_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
    outcome.refuse |-> (!outcome.sell && !outcome.change));

  assert_change_needs_sale_R6: assert property (@(posedge clk) disable iff (rst)
    outcome.change |-> outcome.sell);

  assert_idle_without_request_R2: assert property (@(posedge clk) disable iff (rst)
    !request |=> (outcome == '0));

  assert_one_stage_answer_R11: assert property (@(posedge clk) disable iff (rst)
    request |=> (outcome.sell || outcome.refuse));

  assert_bad_purse_refused_R3: assert property (@(posedge clk) disable iff (rst)
    (request && !purse_ok) |=> (outcome.refuse && !outcome.sell));
endmodule

// File: rtl/coin_vend_decider.sv
module coin_vend_decider
  import coin_vend_pkg::*;
#(
  parameter int PRICE_CENTS   = 35,
  parameter int DIME_SLOTS    = 3,
  parameter int QUARTER_SLOTS = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [DIME_SLOTS-1:0]    dime_slot,
  input  logic [QUARTER_SLOTS-1:0] quarter_slot,
  input  logic                     nickel_slot,
  input  logic                     buy_request,
  output logic                     sale_ok,
  output logic                     give_change,
  output logic                     sale_refused
);
  localparam int NICKEL_EN = (PRICE_CENTS >= NICKEL_PRICE) ? 1 : 0;
  localparam int MAX_COINS = (NICKEL_EN != 0) ? 4 : 3;
  localparam int MAX_VALUE = DIME_SLOTS * DIME_CENTS + QUARTER_SLOTS * QUARTER_CENTS
                           + NICKEL_CENTS;
  localparam int VW = $clog2(((MAX_VALUE > PRICE_CENTS) ? MAX_VALUE : PRICE_CENTS) + 1);

  logic [VW-1:0] value;
  logic          purse_ok;
  vend_outcome_t outcome;

  coin_purse_value #(
    .DIME_SLOTS(DIME_SLOTS), .QUARTER_SLOTS(QUARTER_SLOTS),
    .NICKEL_EN(NICKEL_EN), .MAX_COINS(MAX_COINS), .VW(VW)
  ) u_purse (
    .dime_slot(dime_slot), .quarter_slot(quarter_slot), .nickel_slot(nickel_slot),
    .value(value), .purse_ok(purse_ok)
  );

  vend_decide #(.PRICE_CENTS(PRICE_CENTS), .VW(VW)) u_decide (
    .clk(clk), .rst(rst), .request(buy_request),
    .purse_ok(purse_ok), .value(value), .outcome(outcome)
  );

  assign sale_ok      = outcome.sell;
  assign give_change  = outcome.change;
  assign sale_refused = outcome.refuse;
endmodule

// File: tb/coin_vend_decider_tb_top.sv
module coin_vend_decider_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] dime = '0;
  logic [1:0] quarter = '0;
  logic       nickel = 1'b0;
  logic       req = 1'b0;
  logic [2:0] got35, got45, got55;
  logic [2:0] exp35, exp45, exp55;
  string      tag35, tag45, tag55;
  int         n_tests = 0;
  int         n_fail = 0;
  bit         finished = 0;

  always #4 clk = ~clk;

  coin_vend_decider #(.PRICE_CENTS(35)) dut_i (
    .clk(clk), .rst(rst), .dime_slot(dime), .quarter_slot(quarter),
    .nickel_slot(nickel), .buy_request(req),
    .sale_ok(got35[2]), .give_change(got35[1]), .sale_refused(got35[0]));
  coin_vend_decider #(.PRICE_CENTS(45)) dut45_i (
    .clk(clk), .rst(rst), .dime_slot(dime), .quarter_slot(quarter),
    .nickel_slot(nickel), .buy_request(req),
    .sale_ok(got45[2]), .give_change(got45[1]), .sale_refused(got45[0]));
  coin_vend_decider #(.PRICE_CENTS(55)) dut55_i (
    .clk(clk), .rst(rst), .dime_slot(dime), .quarter_slot(quarter),
    .nickel_slot(nickel), .buy_request(req),
    .sale_ok(got55[2]), .give_change(got55[1]), .sale_refused(got55[0]));

  // Behavioural model: result is {sell, change, refuse}
  task automatic model(input int price, input logic [2:0] d, input logic [1:0] q,
                       input logic n, input logic r,
                       output logic [2:0] res, output string tag);
    int  val = 0;
    int  coins = 0;
    bit  order_ok = 1;
    int  limit = (price == 55) ? 4 : 3;
    for (int i = 0; i < 3; i++) if (d[i]) begin val += 10; coins++; end
    for (int i = 0; i < 2; i++) if (q[i]) begin val += 25; coins++; end
    for (int i = 1; i < 3; i++) if (d[i] && !d[i-1]) order_ok = 0;
    if (q[1] && !q[0]) order_ok = 0;
    if (price == 55 && n) begin val += 5; coins++; end
    if (!r) begin res = 3'b000; tag = "R2"; end
    else if (!order_ok) begin res = 3'b001; tag = "R3/R4"; end
    else if (coins > limit) begin res = 3'b001; tag = "R9"; end
    else if (val < price) begin res = 3'b001; tag = "R7"; end
    else if (val > price) begin res = 3'b110; tag = "R6"; end
    else begin res = 3'b100; tag = "R5"; end
    if (n && price != 55) tag = {"R10 ", tag};
    if (price != 35) tag = {tag, " R12"};
    tag = {tag, " R11"};
  endtask

  task automatic check(input string name, input logic [2:0] got, input logic [2:0] exp,
                       input string tag);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got sell/change/refuse=%b expected %b", tag, name, got, exp);
    end
    n_tests++;
    if (got[0] && (got[2] || got[1])) begin  // R8 exclusivity
      n_fail++;
      $display("FAIL R8 %s: got %b expected refuse alone", name, got);
    end
  endtask

  task automatic step(input logic [2:0] d, input logic [1:0] q, input logic n, input logic r);
    @(negedge clk);
    check("p35", got35, exp35, tag35);
    check("p45", got45, exp45, tag45);
    check("p55", got55, exp55, tag55);
    dime = d; quarter = q; nickel = n; req = r;
    model(35, d, q, n, r, exp35, tag35);
    model(45, d, q, n, r, exp45, tag45);
    model(55, d, q, n, r, exp55, tag55);
  endtask

  initial begin
    exp35 = '0; exp45 = '0; exp55 = '0;
    tag35 = "R1"; tag45 = "R1"; tag55 = "R1";
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state with a request held
    req = 1'b1; dime = 3'b111;
    @(negedge clk);
    check("rst35", got35, 3'b000, "R1");
    check("rst45", got45, 3'b000, "R1");
    check("rst55", got55, 3'b000, "R1");
    req = 1'b0; dime = '0;
    rst = 1'b0;
    // exhaustive walk, button held then released per pattern
    for (int p = 0; p < 64; p++) begin
      step(p[2:0], p[4:3], p[5], 1'b1);
      step(p[2:0], p[4:3], p[5], 1'b0);
    end
    // button held while purse changes each cycle (R11)
    for (int p = 63; p >= 0; p--) step(p[2:0], p[4:3], p[5], 1'b1);
    step('0, '0, 1'b0, 1'b0);
    step('0, '0, 1'b0, 1'b0);
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #(200000 * 8);
    if (!finished) begin
      finished = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule